// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Keyboard-Enable Override

This block is an 8-bit general-purpose I/O port for an on-chip register bus. Software reaches two byte registers through a simple strobe interface: an output latch and a direction register. Each pin is driven with the latch value when its direction bit is set. When the direction bit is clear, the pin floats as an input. The block puts out per-pin output-enable, output-value and pullup-enable controls for the pad ring. It takes the pad input levels through a synchroniser before they reach the read path.

A separate keyboard-interrupt enable bit comes in for each pin. When it is set, the pin turns into an input with its internal pullup on, whatever the direction and latch bits hold. The register read path ignores this override and follows the direction bit alone. So a pin with its direction bit set reads back the latch even while the keyboard enable holds it as an input. Edge detection and interrupt generation are handled elsewhere.

Top module: `gpio_kbd_port`

## Requirements
- R1: Reset (active-low `rst_n`) clears the latch and the direction register to 0x00. All pins then come up as high-impedance inputs with no pullup, and `bus_rdata` reads 0x00.
- R2: A write strobe at offset 0x00 loads `bus_wdata` into the output latch on that clock edge, whatever the direction bits are. The new latch value shows on `pad_out` from the next cycle.
- R3: The direction register at offset 0x04 takes all 8 bits on a write and returns all 8 bits on a read, whatever the keyboard enables are.
- R4: A read of offset 0x00 returns the latch value for every bit whose direction bit is 1.
- R5: A read of offset 0x00 returns, for every bit whose direction bit is 0, the pad input level sampled two clock edges before the edge that takes the read.
- R6: For any bit whose `kbd_en` is 1, `pad_oe` is 0 and `pad_pu` is 1, whatever the direction and latch bits are.
- R7: For a bit with `kbd_en` 0, `pad_pu` is 0. `pad_oe` equals the direction bit, and `pad_out` carries the latch bit.
- R8: The keyboard enable does not change what a read of offset 0x00 returns: a bit with direction 1 reads the latch even while its `kbd_en` forces the pin to an input.
- R9: Writes to any offset other than 0x00 and 0x04 change neither register, and reads of such offsets return 0x00.
- R10: `bus_rdata` is registered. It carries the read result in the cycle after a `bus_rd` strobe and is 0x00 in any cycle that follows a clock edge without `bus_rd`. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| kbd_en | input | 8 | Per-pin keyboard-interrupt enable (forces input with pullup) |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pullup enable |

## Verification
The bench builds the port with its defaults: 8 bits, offsets 0x00 and 0x04, and two synchroniser stages. With eight pins, one vector can hold every mix of keyboard enable, direction and latch bit side by side, so per-bit independence gets checked in a single read. Two stages keep the pin-to-read latency short. The bench can then change `pad_in` just before back-to-back reads and show that each read returns the level from exactly two edges earlier. Unmapped offsets 0x08 and 0x01 are written and read to show they leave both registers untouched.

// File: rtl/gpio_kbd_pkg.sv
package gpio_kbd_pkg;

    // Register selected by a bus offset
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/gpio_kbd_sync.sv
module gpio_kbd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stage[i] = s_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stage[LAST];

    generate
        if (STAGES > 1) begin : g_chain_chk
            // R5
            stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.stage[LAST] == $past(s_q.stage[LAST-1]));
        end
    endgenerate

endmodule

// File: rtl/gpio_kbd_regs.sv
module gpio_kbd_regs
    import gpio_kbd_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_OFS = 0,
    parameter int DIR_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q
);
    localparam logic [ADDR_W-1:0] DATA_A = DATA_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DIR_A  = DIR_OFS[ADDR_W-1:0];

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] rdata;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;

    always_comb begin
        if (addr == DATA_A)     sel = SEL_DATA;
        else if (addr == DIR_A) sel = SEL_DIR;
        else                    sel = SEL_NONE;
    end

    always_comb begin
        r_d       = r_q;
        r_d.rdata = '0;
        if (rd) begin
            unique case (sel)
                SEL_DATA: begin
                    for (int b = 0; b < WIDTH; b++) begin
                        r_d.rdata[b] = r_q.dir[b] ? r_q.latch[b] : pin_sync[b];
                    end
                end
                SEL_DIR:  r_d.rdata = r_q.dir;
                default:  r_d.rdata = '0;
            endcase
        end
        if (wr) begin
            unique case (sel)
                SEL_DATA: r_d.latch = wdata;
                SEL_DIR:  r_d.dir   = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata   = r_q.rdata;
    assign latch_q = r_q.latch;
    assign dir_q   = r_q.dir;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_q == '0 && dir_q == '0));
    // R2
    latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == DATA_A) |=> latch_q == $past(wdata));
    // R3
    dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == DIR_A) |=> dir_q == $past(wdata));
    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != DATA_A && addr != DIR_A) |=> ($stable(latch_q) && $stable(dir_q)));
    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata == '0);
    // R4
    latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == DATA_A) |=> ((rdata ^ $past(latch_q)) & $past(dir_q)) == '0);
    // R5
    pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == DATA_A) |=> ((rdata ^ $past(pin_sync)) & ~$past(dir_q)) == '0);

endmodule

// File: rtl/gpio_kbd_padctl.sv
module gpio_kbd_padctl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] kbd_en,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] out,
    output logic [WIDTH-1:0] pu
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_pin
            always_comb begin
                if (kbd_en[b]) begin
                    oe[b] = 1'b0;
                    pu[b] = 1'b1;
                end else begin
                    oe[b] = dir[b];
                    pu[b] = 1'b0;
                end
                out[b] = latch[b];
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_kbd_port.sv
module gpio_kbd_port #(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_OFS    = 0,
    parameter int DIR_OFS     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  kbd_en,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_pu
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;

    gpio_kbd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_kbd_regs #(
        .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata),
        .latch_q  (latch_q),
        .dir_q    (dir_q)
    );

    gpio_kbd_padctl #(.WIDTH(WIDTH)) u_pad (
        .latch  (latch_q),
        .dir    (dir_q),
        .kbd_en (kbd_en),
        .oe     (pad_oe),
        .out    (pad_out),
        .pu     (pad_pu)
    );

    // R6
    kbd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & kbd_en) == '0) && ((pad_pu & kbd_en) == kbd_en));
    // R7
    plain_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & ~kbd_en) == '0) && (((pad_oe ^ dir_q) & ~kbd_en) == '0));

endmodule

// File: tb/gpio_kbd_port_tb.sv
module gpio_kbd_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] kbd_en = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pu;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    logic [7:0] m_latch, m_dir, m_rd;
    logic [7:0] m_pipe[$];

    always #5 clk = ~clk;

    gpio_kbd_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_en(kbd_en), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // behavioural model, updated on the same edges as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_latch = 8'h00; m_dir = 8'h00; m_rd = 8'h00;
            m_pipe = {8'h00, 8'h00};
        end else begin
            logic [7:0] seen;
            seen = m_pipe[1];
            m_rd = 8'h00;
            if (bus_rd) begin
                if (bus_addr == 8'h00) begin
                    for (int b = 0; b < 8; b++) m_rd[b] = m_dir[b] ? m_latch[b] : seen[b];
                end else if (bus_addr == 8'h04) begin
                    m_rd = m_dir;
                end
            end
            if (bus_wr && bus_addr == 8'h00) m_latch = bus_wdata;
            if (bus_wr && bus_addr == 8'h04) m_dir = bus_wdata;
            m_pipe.push_front(pad_in);
            void'(m_pipe.pop_back());
        end
    end

    task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            cmp("bus_rdata", bus_rdata, m_rd);
            cmp("pad_oe", pad_oe, m_dir & ~kbd_en);
            cmp("pad_out", pad_out, m_latch);
            cmp("pad_pu", pad_pu, kbd_en);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic bus(logic wr, logic rd, logic [7:0] a, logic [7:0] d);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) step();
        bus(0, 1, 8'h00, 0);
        bus(0, 1, 8'h04, 0);
        step();

        // R3: direction register full width
        cur_req = "R3";
        bus(1, 0, 8'h04, 8'hA5);
        bus(0, 1, 8'h04, 0);
        kbd_en = 8'hFF;
        bus(0, 1, 8'h04, 0);
        kbd_en = 8'h00;

        // R2: latch written while pins are inputs
        cur_req = "R2";
        bus(1, 0, 8'h04, 8'h00);
        bus(1, 0, 8'h00, 8'h3C);
        step();

        // R5: input-mode read returns pin, not latch
        cur_req = "R5";
        pad_in = 8'h96;
        repeat (3) step();
        bus(0, 1, 8'h00, 0);
        // pin changes right before back-to-back reads
        pad_in = 8'h11;
        bus(0, 1, 8'h00, 0);
        pad_in = 8'h22;
        bus(0, 1, 8'h00, 0);
        bus(0, 1, 8'h00, 0);
        bus(0, 1, 8'h00, 0);

        // R4: output-mode read returns latch
        cur_req = "R4";
        bus(1, 0, 8'h04, 8'hFF);
        bus(0, 1, 8'h00, 0);

        // R8 / R6: keyboard enable forces input but read follows dir
        cur_req = "R8";
        kbd_en = 8'hFF;
        pad_in = 8'h00;
        step();
        bus(0, 1, 8'h00, 0);
        cur_req = "R6";
        bus(1, 0, 8'h00, 8'hE7);
        step();

        // R7: plain mixed directions
        cur_req = "R7";
        kbd_en = 8'h00;
        bus(1, 0, 8'h04, 8'h0F);
        pad_in = 8'hA0;
        repeat (2) step();
        bus(0, 1, 8'h00, 0);

        // mixed per-bit combinations
        cur_req = "R6";
        kbd_en = 8'h3C;
        bus(1, 0, 8'h04, 8'hF0);
        bus(1, 0, 8'h00, 8'hC3);
        pad_in = 8'h5A;
        repeat (2) step();
        cur_req = "R8";
        bus(0, 1, 8'h00, 0);

        // R10: simultaneous read and write returns old value
        cur_req = "R10";
        bus(1, 1, 8'h00, 8'h81);
        bus(1, 1, 8'h04, 8'h18);
        bus(0, 1, 8'h04, 0);
        repeat (2) step();

        // R9: unmapped offsets
        cur_req = "R9";
        bus(1, 0, 8'h08, 8'hFF);
        bus(1, 0, 8'h01, 8'h77);
        bus(0, 1, 8'h08, 0);
        bus(0, 1, 8'h01, 0);
        bus(0, 1, 8'h04, 0);
        bus(0, 1, 8'h00, 0);

        // mixed random traffic
        cur_req = "R4";
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic [7:0] a;
            op = 3'($urandom);
            a  = (op[0]) ? 8'h00 : ((op[1]) ? 8'h04 : 8'($urandom));
            kbd_en = 8'($urandom);
            pad_in = 8'($urandom);
            bus_wr = op[2]; bus_rd = $urandom % 2 == 0;
            bus_addr = a; bus_wdata = 8'($urandom);
            step();
        end
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) step();

        // R1: reset again mid-operation
        cur_req = "R1";
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        bus(0, 1, 8'h04, 0);
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule